// File: doc/BRIEF.md
# Downstream Port Power and Over-current Supervisor

This block switches supply power for a small set of downstream hub ports and watches their over-current sense lines. Each port has an active-low power-enable output (low = powered) and an active-low sense input (low = over-current). A sense input only counts while its port is powered. It must stay low for a blanking time, counted in 1 µs ticks, before the block accepts a fault. This lets the inrush current at device attach pass without a trip. Once a fault is accepted, the block removes power from the affected ports. It also sets a sticky over-current flag and a status-change flag for hub logic to read.

Two static configuration inputs select the topology. Switching is either per port or ganged across all ports. Sensing is either per port or global, and global sensing uses sense input 0 for the whole hub. Hub logic turns ports on and off with one-clock command pulses, and clears the flags with a one-clock clear pulse per port.

Top module: `port_pwr_sup`

## Requirements
- R1: While reset is asserted and right after it, every `pwr_en_n` bit is 1 (unpowered) and every `oc_sticky` and `oc_change` bit is 0.
- R2: If a powered port's sense input goes low and stays low, its `pwr_en_n` goes to 1 no sooner than BLANK_US ticks and no later than RESP_US ticks after the fall (defaults 4000 and 5000).
- R3: A low pulse on a powered port's sense input that is shorter than BLANK_US ticks (for example 3900) causes no trip and sets no flag, and the port stays powered.
- R4: A sense input is ignored while its port is unpowered. A fault there sets no flag, and a later power-on command powers the port.
- R5: With `gang_sw`=1, an on or off pulse on any command bit applies to every port. A fault on any sense input removes power from all ports, and every port sets `oc_sticky` and `oc_change`.
- R6: With `glob_sense`=1, only `oc_n[0]` is used. It is honoured while any port is powered, and a fault on it removes power from every powered port. Sense inputs 1 and up have no effect.
- R7: A tripped port stays unpowered until a new `pwr_on_req` pulse arrives. An off pulse unpowers a port, a trip overrides both commands in the same cycle, and off overrides on.
- R8: `oc_sticky[i]` and `oc_change[i]` are set on the clock edge that trips port i. They hold until a clear pulse on `oc_clr[i]`. When a trip and a clear fall on the same edge, the flags end set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-clock pulse every microsecond |
| gang_sw | input | 1 | 1 = ganged switching, 0 = per-port switching |
| glob_sense | input | 1 | 1 = global sensing on input 0, 0 = per-port sensing |
| pwr_on_req | input | NPORT | One-clock power-on command per port |
| pwr_off_req | input | NPORT | One-clock power-off command per port |
| oc_clr | input | NPORT | One-clock clear of the sticky and change flags |
| oc_n | input | NPORT | Over-current sense, active low, asynchronous |
| pwr_en_n | output | NPORT | Power enable, active low |
| oc_sticky | output | NPORT | Sticky over-current flag |
| oc_change | output | NPORT | Over-current status-change flag |

## Verification
A fault trip and a software flag clear can land on the same clock edge. When they do, the trip must win. The bench first measures the exact edge on which a sustained fault removes power, starting from a reset with a fixed tick phase. It then repeats the same run with the clear pulse placed on that edge, and expects the sticky flag to be set afterwards. A second clear pulse then proves that clearing works on its own.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // The blanking count has been reached.
  function automatic logic blank_reached(input int unsigned cnt, input int unsigned lim);
    return (cnt >= lim);
  endfunction

  // The detector index that serves port i under the sensing mode.
  function automatic int unsigned sense_src(input int unsigned i, input logic glob);
    return glob ? 0 : i;
  endfunction

  // A command bit reaches port i: any bit when ganged, own bit otherwise.
  function automatic logic cmd_hit(input logic own, input logic any, input logic gang);
    return gang ? any : own;
  endfunction

endpackage

// File: rtl/pps_oc_det.sv
module pps_oc_det #(
  parameter int unsigned BLANK_US    = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic sense_n,
  input  logic armed,
  output logic fault
);
  import pps_pkg::*;

  localparam int unsigned CW = $clog2(BLANK_US + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   sense_lo;
  logic                   active;
  logic                   reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sense_n};
  end

  assign sense_lo = ~sync_q[SYNC_STAGES-1];
  assign active   = sense_lo & armed;
  assign reached  = blank_reached(int'(cnt_q), BLANK_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!active)             cnt_q <= '0;
    else if (tick_us && !reached) cnt_q <= cnt_q + 1'b1;
  end

  assign fault = active & reached;
endmodule

// File: rtl/pps_port_ctl.sv
module pps_port_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic on_cmd,
  input  logic off_cmd,
  input  logic clr,
  output logic pwr_en_n,
  output logic sticky,
  output logic change
);
  logic powered_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       powered_q <= 1'b0;
    else if (trip)    powered_q <= 1'b0;
    else if (off_cmd) powered_q <= 1'b0;
    else if (on_cmd)  powered_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= 1'b0;
      change <= 1'b0;
    end else if (trip) begin
      sticky <= 1'b1;
      change <= 1'b1;
    end else if (clr) begin
      sticky <= 1'b0;
      change <= 1'b0;
    end
  end

  assign pwr_en_n = ~powered_q;
endmodule

// File: rtl/port_pwr_sup.sv
module port_pwr_sup #(
  parameter int unsigned NPORT       = 4,
  parameter int unsigned BLANK_US    = 4000,
  parameter int unsigned RESP_US     = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             gang_sw,
  input  logic             glob_sense,
  input  logic [NPORT-1:0] pwr_on_req,
  input  logic [NPORT-1:0] pwr_off_req,
  input  logic [NPORT-1:0] oc_clr,
  input  logic [NPORT-1:0] oc_n,
  output logic [NPORT-1:0] pwr_en_n,
  output logic [NPORT-1:0] oc_sticky,
  output logic [NPORT-1:0] oc_change
);
  import pps_pkg::*;

  logic [NPORT-1:0] powered;
  logic [NPORT-1:0] det_armed;
  logic [NPORT-1:0] det_fault;
  logic [NPORT-1:0] port_fault;
  logic [NPORT-1:0] trip_port;
  logic             any_on;
  logic             any_off;
  logic             any_fault;
  logic             any_powered;

  assign powered     = ~pwr_en_n;
  assign any_on      = |pwr_on_req;
  assign any_off     = |pwr_off_req;
  assign any_powered = |powered;
  assign any_fault   = |port_fault;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    if (i == 0) begin : g_arm0
      assign det_armed[i] = glob_sense ? any_powered : powered[i];
    end else begin : g_armn
      assign det_armed[i] = glob_sense ? 1'b0 : powered[i];
    end

    pps_oc_det #(
      .BLANK_US   (BLANK_US),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_us(tick_us),
      .sense_n(oc_n[i]),
      .armed  (det_armed[i]),
      .fault  (det_fault[i])
    );

    assign port_fault[i] = det_fault[sense_src(i, glob_sense)];
    assign trip_port[i]  = powered[i] & cmd_hit(port_fault[i], any_fault, gang_sw);

    pps_port_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip    (trip_port[i]),
      .on_cmd  (cmd_hit(pwr_on_req[i], any_on, gang_sw)),
      .off_cmd (cmd_hit(pwr_off_req[i], any_off, gang_sw)),
      .clr     (oc_clr[i]),
      .pwr_en_n(pwr_en_n[i]),
      .sticky  (oc_sticky[i]),
      .change  (oc_change[i])
    );
  end
endmodule

// File: rtl/port_pwr_sup_chk.sv
module port_pwr_sup_chk #(
  parameter int unsigned NPORT   = 4,
  parameter int unsigned RESP_US = 5000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             gang_sw,
  input logic             glob_sense,
  input logic [NPORT-1:0] pwr_on_req,
  input logic [NPORT-1:0] oc_clr,
  input logic [NPORT-1:0] oc_n,
  input logic [NPORT-1:0] pwr_en_n,
  input logic [NPORT-1:0] oc_sticky,
  input logic [NPORT-1:0] trip_evt
);
  localparam int unsigned WW = $clog2(RESP_US + 2);

  logic uniform;
  assign uniform = (pwr_en_n == '0) || (pwr_en_n == '1);

  a_r1_reset_unpowered: assert property (@(posedge clk)
    !rst_n |-> ((&pwr_en_n) && (oc_sticky == '0)));

  a_r5_gang_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (gang_sw && $past(gang_sw) && $past(uniform)) |-> uniform);

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    logic [WW-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else if (!gang_sw && !glob_sense && !oc_n[i] && !pwr_en_n[i]) begin
        if (tick_us && (win_q <= WW'(RESP_US))) win_q <= win_q + 1'b1;
      end else win_q <= '0;
    end

    a_r2_cut_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      win_q <= WW'(RESP_US));

    a_r4_trip_only_powered: assert property (@(posedge clk) disable iff (!rst_n)
      trip_evt[i] |-> !pwr_en_n[i]);

    a_r4_flag_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_sticky[i]) |-> $past(!pwr_en_n[i]));

    a_r7_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_en_n[i] && !(gang_sw ? (|pwr_on_req) : pwr_on_req[i])) |=> pwr_en_n[i]);

    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_sticky[i] && !oc_clr[i]) |=> oc_sticky[i]);
  end
endmodule

bind port_pwr_sup port_pwr_sup_chk #(
  .NPORT  (NPORT),
  .RESP_US(RESP_US)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_us   (tick_us),
  .gang_sw   (gang_sw),
  .glob_sense(glob_sense),
  .pwr_on_req(pwr_on_req),
  .oc_clr    (oc_clr),
  .oc_n      (oc_n),
  .pwr_en_n  (pwr_en_n),
  .oc_sticky (oc_sticky),
  .trip_evt  (trip_port)
);

// File: tb/port_pwr_sup_bench.sv
module port_pwr_sup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  // Ticks every 2 clocks, so a trip at 4000..5000 ticks lands at 8000..10000 clocks.
  localparam int MIN_CLK = 8000;
  localparam int MAX_CLK = 10000;

  // Entry: {gang, glob, port[1:0], low_us[12:0], expected_off[3:0]}
  localparam logic [20:0] TBL [5] = '{
    {1'b0, 1'b0, 2'd1, 13'd3900, 4'b0000},  // R3 short pulse
    {1'b0, 1'b0, 2'd2, 13'd4500, 4'b0100},  // R2 single port trip
    {1'b1, 1'b0, 2'd3, 13'd4500, 4'b1111},  // R5 ganged trip
    {1'b0, 1'b1, 2'd0, 13'd4500, 4'b1111},  // R6 global trip
    {1'b0, 1'b1, 2'd2, 13'd4500, 4'b0000}   // R6 other sense ignored
  };

  logic clk = 0, rst_n = 0, tick_us, gang_sw = 0, glob_sense = 0;
  logic [NP-1:0] pwr_on_req = '0, pwr_off_req = '0, oc_clr = '0, oc_n = '1;
  logic [NP-1:0] pwr_en_n, oc_sticky, oc_change;
  int n_run = 0, n_fail = 0;
  int k1, k2;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_us <= 1'b0;
    else        tick_us <= ~tick_us;
  end

  port_pwr_sup u_port_pwr_sup (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .gang_sw(gang_sw),
    .glob_sense(glob_sense), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .oc_clr(oc_clr), .oc_n(oc_n), .pwr_en_n(pwr_en_n), .oc_sticky(oc_sticky),
    .oc_change(oc_change)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic g, input logic gl);
    rst_n = 0; gang_sw = g; glob_sense = gl;
    pwr_on_req = '0; pwr_off_req = '0; oc_clr = '0; oc_n = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic pulse_on(input logic [NP-1:0] m);
    pwr_on_req = m; @(posedge clk); #1; pwr_on_req = '0;
  endtask

  task automatic pulse_off(input logic [NP-1:0] m);
    pwr_off_req = m; @(posedge clk); #1; pwr_off_req = '0;
  endtask

  task automatic pulse_clr(input logic [NP-1:0] m);
    oc_clr = m; @(posedge clk); #1; oc_clr = '0;
  endtask

  // Hold sense p low for a number of clocks; clr_at > 0 places a clear on that edge.
  task automatic fault_run(input int p, input int clocks, input int clr_at, output int k);
    k = -1;
    oc_n[p] = 1'b0;
    for (int j = 1; j <= clocks; j++) begin
      @(posedge clk); #1;
      if (k < 0 && pwr_en_n[p]) k = j;
      if (clr_at > 0 && j == clr_at - 1) oc_clr[p] = 1'b1;
      if (clr_at > 0 && j == clr_at)     oc_clr[p] = 1'b0;
    end
    oc_n[p] = 1'b1;
    repeat (6) @(posedge clk); #1;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k;
    #1;
    check(pwr_en_n == '1, "R1 pwr_en_n in reset", pwr_en_n, 15);
    check(oc_sticky == '0 && oc_change == '0, "R1 flags in reset", oc_sticky, 0);
    do_reset(0, 0);
    check(pwr_en_n == '1, "R1 pwr_en_n after reset", pwr_en_n, 15);

    foreach (TBL[e]) begin
      logic [3:0] exp_off;
      int p, us;
      exp_off = TBL[e][3:0];
      us = int'(TBL[e][16:4]);
      p = int'(TBL[e][18:17]);
      do_reset(TBL[e][20], TBL[e][19]);
      pulse_on('1);
      check(pwr_en_n == '0, "R7 on command powers ports", pwr_en_n, 0);
      fault_run(p, us * 2, 0, k);
      check(pwr_en_n == exp_off, "R2/R3/R5/R6 power after fault", pwr_en_n, exp_off);
      check(oc_sticky == exp_off, "R8 sticky after fault", oc_sticky, exp_off);
      check(oc_change == exp_off, "R5/R8 change after fault", oc_change, exp_off);
      if (exp_off != 0)
        check(k >= MIN_CLK && k <= MAX_CLK, "R2 cut window (clocks)", k, MIN_CLK);
    end

    // R4: fault on an unpowered port is ignored.
    do_reset(0, 0);
    pulse_on(4'b1110);
    fault_run(0, 9000, 0, k);
    check(oc_sticky == '0 && oc_change == '0, "R4 no flag while off", oc_sticky, 0);
    pulse_on(4'b0001);
    check(pwr_en_n == '0, "R4 port powers later", pwr_en_n, 0);

    // R7/R8: trip stays off, re-power, sticky holds until clear; off command.
    do_reset(0, 0);
    pulse_on('1);
    fault_run(1, 9000, 0, k1);
    repeat (50) @(posedge clk); #1;
    check(pwr_en_n == 4'b0010, "R7 tripped port stays off", pwr_en_n, 2);
    pulse_on(4'b0010);
    check(pwr_en_n == '0, "R7 re-power after trip", pwr_en_n, 0);
    check(oc_sticky == 4'b0010, "R8 sticky holds after re-power", oc_sticky, 2);
    pulse_clr(4'b0010);
    check(oc_sticky == '0 && oc_change == '0, "R8 clear", oc_sticky, 0);
    pulse_off(4'b0100);
    check(pwr_en_n == 4'b0100, "R7 off command", pwr_en_n, 4);
    pwr_on_req = 4'b1000; pwr_off_req = 4'b1000; @(posedge clk); #1;
    pwr_on_req = '0; pwr_off_req = '0;
    check(pwr_en_n[3] == 1'b1, "R7 off beats on", pwr_en_n[3], 1);

    // R5: ganged command.
    do_reset(1, 0);
    pulse_on(4'b0100);
    check(pwr_en_n == '0, "R5 gang on", pwr_en_n, 0);
    pulse_off(4'b0001);
    check(pwr_en_n == '1, "R5 gang off", pwr_en_n, 15);

    // R8: trip and clear on the same edge.
    do_reset(0, 0);
    pulse_on('1);
    fault_run(2, 9000, 0, k1);
    do_reset(0, 0);
    pulse_on('1);
    fault_run(2, 9000, k1, k2);
    check(k2 == k1, "R8 trip edge repeatable", k2, k1);
    check(oc_sticky[2] == 1'b1 && oc_change[2] == 1'b1, "R8 trip beats clear", oc_sticky[2], 1);
    pulse_clr(4'b0100);
    check(oc_sticky[2] == 1'b0, "R8 later clear", oc_sticky[2], 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule